// File: doc/BRIEF.md
# Mode-Selectable Five-Decade BCD Counter

This block is a synchronous decimal counter built from five cascaded BCD stages, all clocked by the system clock. A count event is a clock edge at which the `cnt_en` strobe is high. Every count event advances the first stage. Two mode pins decide which transition of the first stage carries into the second stage, and what the first stage's output shows.

The four modes are a plain five-decade chain, a test mode that steps several stages at once, a four-decade count whose front stage divides by ten with round-off, and a four-decade count with half-unit resolution. The upper four stages always appear raw on the output bus. The lowest nibble shows the first stage as it is, rounded to 0 or 5, or blanked, depending on the mode. A flag marks when that nibble is meaningful. The block has no data stream: the strobe and the mode pins are plain control inputs and have no back-pressure.

Top module: `bcd5_mode_counter`

## Requirements
- R1: When `rst` is high at a clock edge, every stage becomes 0 on that edge, even if `cnt_en` is also high.
- R2: A count event advances stage 1 by one, and 9 wraps to 0. A clock edge with `cnt_en` low changes no stage. A stage never holds a value above 9.
- R3: Mode `{mode_a,mode_b}`=00 (chain): stage 2 advances only on the event where stage 1 goes from 9 to 0. `disp_o[3:0]` shows stage 1 raw, and `first_valid_o` is 1.
- R4: Stage 3 advances on the event where stage 2 goes from 9 to 0, and stage 5 on the event where stage 4 goes from 9 to 0. This holds in every mode, and the whole ripple settles within that one event. Outside test mode, stage 4 advances on the event where stage 3 wraps.
- R5: Mode 01 (test): every count event advances stages 1, 2 and 4 directly, and the first-stage output is blanked.
- R6: Mode 11 (round-off): stage 2 advances on the event where stage 1 goes from 4 to 5, and the first-stage output is blanked.
- R7: Mode 10 (half-unit): stage 2 advances on the event where stage 1 goes from 7 to 8. `disp_o[3:0]` reads 5 while stage 1 holds 3 to 7 and reads 0 while it holds 8, 9, 0, 1 or 2. `first_valid_o` is 1.
- R8: While the first-stage output is blanked, `disp_o[3:0]` is 4'hF and `first_valid_o` is 0.
- R9: The mode pins take effect without a register. Carry routing uses the mode present at the event's clock edge, and the first-stage view follows the mode pins at once.
- R10: `disp_o[4k+3:4k]` for k = 1 to 4 is the raw BCD value of stage k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear |
| cnt_en | input | 1 | Count-event strobe, sampled on the rising edge |
| mode_a | input | 1 | Upper mode-select bit |
| mode_b | input | 1 | Lower mode-select bit |
| disp_o | output | 20 | Five digits: first-stage view in [3:0], raw stages 2 to 5 above it |
| first_valid_o | output | 1 | High when disp_o[3:0] carries a digit |

## Verification
The stage registers change on the same clock edge that samples the strobe. The whole carry ripple is combinational, so every digit is due one edge after its event, and the bench reads all digits at the falling edge that follows. The first-stage view and its valid flag are combinational from the mode pins, so the bench reads them a short delay after it changes the mode, with no clock in between. Strobes and mode changes are driven on falling edges, which keeps each sample exactly one rising edge away from its cause.

// File: rtl/bcd5_pkg.sv
package bcd5_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] BLANK_CODE = 4'hF;

  typedef enum logic [1:0] {
    MODE_CHAIN = 2'b00,
    MODE_TEST  = 2'b01,
    MODE_HALF  = 2'b10,
    MODE_ROUND = 2'b11
  } mode_e;
endpackage

// File: rtl/bcd_stage.sv
module bcd_stage
  import bcd5_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  output logic [DIGIT_W-1:0] digit,
  output logic               at_nine
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(9);

  always_ff @(posedge clk) begin
    if (rst) digit <= '0;
    else if (inc) digit <= (digit == TOP) ? '0 : digit + 1'b1;
  end

  assign at_nine = (digit == TOP);

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    digit <= TOP);
  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && digit == TOP) |=> digit == '0);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(digit));
endmodule

// File: rtl/carry_router.sv
module carry_router
  import bcd5_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int BYPASS_IDX = 3
) (
  input  logic               ev,
  input  mode_e              mode,
  input  logic [DIGIT_W-1:0] first_digit,
  input  logic [NUM_STAGES-1:0] at_nine,
  output logic [NUM_STAGES-1:0] inc
);
  logic [DIGIT_W-1:0] tap;
  logic               test_mode;

  always_comb begin
    case (mode)
      MODE_ROUND: tap = DIGIT_W'(4);
      MODE_HALF:  tap = DIGIT_W'(7);
      default:    tap = DIGIT_W'(9);
    endcase
  end

  assign test_mode = (mode == MODE_TEST);

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_inc
    if (k == 0) begin : g_first
      assign inc[k] = ev;
    end else if (k == 1) begin : g_second
      assign inc[k] = test_mode ? ev : (ev && first_digit == tap);
    end else if (k == BYPASS_IDX) begin : g_bypass
      assign inc[k] = test_mode ? ev : (inc[k-1] && at_nine[k-1]);
    end else begin : g_ripple
      assign inc[k] = inc[k-1] && at_nine[k-1];
    end
  end
endmodule

// File: rtl/first_stage_view.sv
module first_stage_view
  import bcd5_pkg::*;
(
  input  mode_e              mode,
  input  logic [DIGIT_W-1:0] digit,
  output logic [DIGIT_W-1:0] view,
  output logic               valid
);
  always_comb begin
    view  = BLANK_CODE;
    valid = 1'b0;
    case (mode)
      MODE_CHAIN: begin
        view  = digit;
        valid = 1'b1;
      end
      MODE_HALF: begin
        view  = (digit >= DIGIT_W'(3) && digit <= DIGIT_W'(7)) ? DIGIT_W'(5) : '0;
        valid = 1'b1;
      end
      default: begin
        view  = BLANK_CODE;
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bcd5_mode_counter.sv
module bcd5_mode_counter
  import bcd5_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int BYPASS_IDX = 3,
  localparam int OUT_W = NUM_STAGES * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             mode_a,
  input  logic             mode_b,
  output logic [OUT_W-1:0] disp_o,
  output logic             first_valid_o
);
  mode_e                   mode;
  logic [DIGIT_W-1:0]      dig [NUM_STAGES];
  logic [NUM_STAGES-1:0]   at_nine;
  logic [NUM_STAGES-1:0]   inc;
  logic [DIGIT_W-1:0]      first_view;

  assign mode = mode_e'({mode_a, mode_b});

  carry_router #(.NUM_STAGES(NUM_STAGES), .BYPASS_IDX(BYPASS_IDX)) router_i (
    .ev(cnt_en), .mode(mode), .first_digit(dig[0]), .at_nine(at_nine), .inc(inc)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    bcd_stage stage_i (
      .clk(clk), .rst(rst), .inc(inc[k]), .digit(dig[k]), .at_nine(at_nine[k])
    );
    if (k == 0) begin : g_view
      assign disp_o[DIGIT_W-1:0] = first_view;
    end else begin : g_raw
      assign disp_o[k*DIGIT_W +: DIGIT_W] = dig[k];
    end
  end

  first_stage_view view_i (
    .mode(mode), .digit(dig[0]), .view(first_view), .valid(first_valid_o)
  );

  // R3
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CHAIN && cnt_en && dig[0] != DIGIT_W'(9)) |=> $stable(dig[1]));
  // R5
  test_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TEST && cnt_en) |=> (dig[1] != $past(dig[1]) && dig[BYPASS_IDX] != $past(dig[BYPASS_IDX])));
  // R6
  round_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ROUND && cnt_en && dig[0] == DIGIT_W'(4)) |=> dig[1] != $past(dig[1]));
  // R7
  half_view_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALF) |-> (disp_o[DIGIT_W-1:0] == '0 || disp_o[DIGIT_W-1:0] == DIGIT_W'(5)));
  // R8
  blank_code_chk: assert property (@(posedge clk) disable iff (rst)
    !first_valid_o |-> disp_o[DIGIT_W-1:0] == BLANK_CODE);
endmodule

// File: tb/bcd5_mode_counter_tb_top.sv
module bcd5_mode_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        mode_a = 1'b0;
  logic        mode_b = 1'b0;
  logic [19:0] disp_o;
  logic        first_valid_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bcd5_mode_counter dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode_a(mode_a), .mode_b(mode_b),
    .disp_o(disp_o), .first_valid_o(first_valid_o)
  );

  // {mode[1:0], events[15:0], expected disp[19:0], expected valid}
  localparam int NV = 19;
  localparam logic [38:0] VEC [NV] = '{
    {2'b00, 16'd0,    20'h00000, 1'b1},  // R1 R3 reset state
    {2'b00, 16'd9,    20'h00009, 1'b1},  // R2 R3
    {2'b00, 16'd10,   20'h00010, 1'b1},  // R3 9->0 carry
    {2'b00, 16'd123,  20'h00123, 1'b1},  // R4 R10
    {2'b00, 16'd1000, 20'h01000, 1'b1},  // R4
    {2'b00, 16'd9999, 20'h09999, 1'b1},  // R4
    {2'b01, 16'd0,    20'h0000F, 1'b0},  // R5 R8
    {2'b01, 16'd7,    20'h0707F, 1'b0},  // R5
    {2'b01, 16'd10,   20'h1010F, 1'b0},  // R5 R4
    {2'b01, 16'd25,   20'h2525F, 1'b0},  // R5
    {2'b11, 16'd4,    20'h0000F, 1'b0},  // R6
    {2'b11, 16'd5,    20'h0001F, 1'b0},  // R6 4->5 carry
    {2'b11, 16'd15,   20'h0002F, 1'b0},  // R6
    {2'b11, 16'd105,  20'h0011F, 1'b0},  // R6 R4
    {2'b10, 16'd2,    20'h00000, 1'b1},  // R7
    {2'b10, 16'd3,    20'h00005, 1'b1},  // R7
    {2'b10, 16'd7,    20'h00005, 1'b1},  // R7
    {2'b10, 16'd8,    20'h00010, 1'b1},  // R7 7->8 carry
    {2'b10, 16'd13,   20'h00015, 1'b1}   // R7
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp,
                       input logic av, input logic ev);
    n_checks++;
    if (act !== exp || av !== ev) begin
      n_fail++;
      $display("FAIL %s: disp=%h valid=%b expected disp=%h valid=%b", req, act, av, exp, ev);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    {mode_a, mode_b} = m;
    #1;
  endtask

  task automatic run_events(input int n);
    if (n > 0) begin
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string req;
      case (VEC[i][38:37])
        2'b00:   req = "R3";
        2'b01:   req = "R5";
        2'b11:   req = "R6";
        default: req = "R7";
      endcase
      do_reset();
      set_mode(VEC[i][38:37]);
      run_events(int'(VEC[i][36:21]));
      #1;
      check(req, disp_o, VEC[i][20:1], first_valid_o, VEC[i][0]);
    end

    // R4: 09999 plus one event ripples into stage 5
    do_reset();
    set_mode(2'b00);
    run_events(9999);
    run_events(1);
    #1 check("R4", disp_o, 20'h10000, first_valid_o, 1'b1);

    // R2: idle edges change nothing
    repeat (5) @(negedge clk);
    #1 check("R2", disp_o, 20'h10000, first_valid_o, 1'b1);

    // R1: reset wins over a simultaneous count strobe
    @(negedge clk) begin rst = 1'b1; cnt_en = 1'b1; end
    @(negedge clk) begin rst = 1'b0; cnt_en = 1'b0; end
    #1 check("R1", disp_o, 20'h00000, first_valid_o, 1'b1);

    // R9: the view follows the mode pins with no clock edge
    run_events(4);
    set_mode(2'b10);
    check("R9", disp_o, 20'h00005, first_valid_o, 1'b1);
    set_mode(2'b01);
    check("R9", disp_o, 20'h0000F, first_valid_o, 1'b0);
    set_mode(2'b11);
    check("R8", disp_o, 20'h0000F, first_valid_o, 1'b0);

    // R9: the mode at the event edge picks the carry tap (4->5 in round-off)
    run_events(1);
    #1 check("R9", disp_o, 20'h0001F, first_valid_o, 1'b0);
    set_mode(2'b00);
    check("R9", disp_o, 20'h00015, first_valid_o, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule